// File: doc/BRIEF.md
# Four-Level Bus Arbiter

This block is the central arbiter of a shared parallel backplane bus. Cards ask for the bus on four active-low request lines, one per priority level, and the arbiter answers by driving exactly one of four active-low grant lines. The grant enters a daisy chain that passes along the cards of that level. The card that takes the grant answers by pulling the shared active-low busy line, and the arbiter then removes its grant. It does not arbitrate again until busy is released.

Three policies are chosen with a two-bit select. Fixed priority always serves the highest pending level. Rotating priority walks downward from the level granted last. Single-level operation serves only the top request line. In fixed-priority mode the arbiter can also ask the current owner to give up the bus: it drives an active-low clear line when a more urgent request is waiting. An offered grant that nobody answers with busy is taken back after a parameterised number of cycles. All bus inputs pass through a two-flop synchronizer before they are used.

Top module: `busreq_arbiter`

## Requirements
- R1: Out of reset every grant_n line and clear_n are high (inactive). With no request pending, no grant is ever driven.
- R2: At most one grant_n bit is low at any time. Bit i of grant_n answers bit i of req_n (request level i).
- R3: With policy 2'b00 (fixed), the highest-numbered pending request level receives the grant. Level 3 is the most urgent and level 0 the least.
- R4: With policy 2'b01 (rotating), the search starts one level below the level granted last and moves downward, wrapping from level 0 to level 3. The level granted last is searched last. After reset the search starts at level 3.
- R5: With policy 2'b10 or 2'b11 (single-level), only request level 3 is ever granted. Requests on levels 0 to 2 get no grant.
- R6: A grant is issued only while the synchronized busy_n is high. While busy_n is held low, no new grant appears.
- R7: Once the synchronized busy_n is seen low, the grant is withdrawn at the next clock edge. Arbitration resumes only after busy_n returns high.
- R8: A grant that is not answered by busy_n low stays low for exactly TIMEOUT_CYCLES cycles and is then withdrawn for at least one cycle. If the request is still pending, it is then offered again.
- R9: clear_n goes low only with policy 2'b00, only while the bus is owned and busy_n is low, and only if a request level strictly above the owner's level is pending. A request at the owner's level or below never drives it low.
- R10: req_n and busy_n are sampled through two flip-flops. A request change driven before rising edge k is reflected on grant_n right after rising edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | Arbitration policy: 00 fixed, 01 rotating, 1x single-level |
| req_n | input | LEVELS | Active-low bus request lines, bit i is level i |
| busy_n | input | 1 | Active-low bus-busy line driven by the owning master |
| grant_n | output | LEVELS | Active-low grant lines into the daisy chains |
| clear_n | output | 1 | Active-low request for the current owner to release the bus |

## Verification
The rotating test holds all four requests and plays master for each grant. A pointer that fails to advance, or that walks upward, repeats level 3 or gives the wrong order. It then checks that a level just served is searched last. The preemption test raises requests at the owner's level, below it and above it, and repeats the higher case in the other policies. A design that compares with greater-or-equal, or ignores the policy, pulls clear_n low there. The unanswered-grant test counts the exact number of cycles the grant is held and checks the re-offer that follows. An off-by-one timer or a missing withdrawal changes that count. Direct sampling of the request path exposes one synchronizer stage too many or too few, and a request raised while busy is held exposes a grant issued during ownership.

// File: rtl/busreq_arb_pkg.sv
`timescale 1ns/1ps
package busreq_arb_pkg;

    typedef enum logic [1:0] {
        POL_FIXED   = 2'b00,
        POL_ROTATE  = 2'b01,
        POL_SINGLE  = 2'b10,
        POL_SINGLE2 = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_OFFER = 2'b01,
        ST_OWNED = 2'b10
    } arb_state_e;

    function automatic logic pol_is_single(policy_e p);
        return p[1];
    endfunction

endpackage

// File: rtl/busreq_sync.sv
`timescale 1ns/1ps
module busreq_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= {WIDTH{RST_VAL}};
            end
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/busreq_pick.sv
`timescale 1ns/1ps
module busreq_pick
    import busreq_arb_pkg::*;
#(
    parameter int unsigned LEVELS = 4,
    parameter int unsigned LVL_W  = 2
) (
    input  logic [LEVELS-1:0] req_act,
    input  policy_e           pol,
    input  logic [LVL_W-1:0]  last_lvl,
    output logic              found,
    output logic [LVL_W-1:0]  pick
);

    logic [LVL_W-1:0] idx;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        idx   = '0;
        if (pol_is_single(pol)) begin
            found = req_act[LEVELS-1];
            pick  = LVL_W'(LEVELS-1);
        end else if (pol == POL_ROTATE) begin
            // later hits override: s == 1 (one below last) wins
            for (int s = LEVELS; s >= 1; s--) begin
                idx = last_lvl - LVL_W'(s);
                if (req_act[idx]) begin
                    found = 1'b1;
                    pick  = idx;
                end
            end
        end else begin
            // ascending scan: highest pending level wins
            for (int i = 0; i < LEVELS; i++) begin
                if (req_act[i]) begin
                    found = 1'b1;
                    pick  = LVL_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/busreq_grant_fsm.sv
`timescale 1ns/1ps
module busreq_grant_fsm
    import busreq_arb_pkg::*;
#(
    parameter int unsigned LEVELS         = 4,
    parameter int unsigned LVL_W          = 2,
    parameter int unsigned TIMEOUT_CYCLES = 16,
    parameter int unsigned TMR_W          = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_act,
    input  logic              found,
    input  logic [LVL_W-1:0]  pick,
    output logic [LEVELS-1:0] grant_vec,
    output logic [LVL_W-1:0]  cur_lvl,
    output logic              owned
);

    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

    arb_state_e       st_q;
    logic [LVL_W-1:0] lvl_q;
    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            lvl_q <= '0;
            tmr_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (!busy_act && found) begin
                        st_q  <= ST_OFFER;
                        lvl_q <= pick;
                        tmr_q <= '0;
                    end
                end
                ST_OFFER: begin
                    if (busy_act) begin
                        st_q <= ST_OWNED;
                    end else if (tmr_q == TMR_LAST) begin
                        st_q <= ST_IDLE;
                    end else begin
                        tmr_q <= tmr_q + TMR_W'(1);
                    end
                end
                ST_OWNED: begin
                    if (!busy_act) begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        grant_vec = '0;
        if (st_q == ST_OFFER) begin
            grant_vec[lvl_q] = 1'b1;
        end
    end

    assign cur_lvl = lvl_q;
    assign owned   = (st_q == ST_OWNED);

endmodule

// File: rtl/busreq_arbiter.sv
`timescale 1ns/1ps
module busreq_arbiter
    import busreq_arb_pkg::*;
#(
    parameter int unsigned LEVELS         = 4,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned TIMEOUT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        policy,
    input  logic [LEVELS-1:0] req_n,
    input  logic              busy_n,
    output logic [LEVELS-1:0] grant_n,
    output logic              clear_n
);

    localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int unsigned TMR_W  = $clog2(TIMEOUT_CYCLES + 1);
    localparam int unsigned SYNC_W = LEVELS + 1;

    policy_e           pol;
    logic [SYNC_W-1:0] line_sync;
    logic [LEVELS-1:0] req_act;
    logic              busy_act;
    logic              found;
    logic [LVL_W-1:0]  pick;
    logic [LEVELS-1:0] grant_vec;
    logic [LVL_W-1:0]  cur_lvl;
    logic              owned;
    logic              higher_pending;

    assign pol = policy_e'(policy);

    busreq_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({busy_n, req_n}),
        .dout(line_sync)
    );

    assign req_act  = ~line_sync[LEVELS-1:0];
    assign busy_act = ~line_sync[LEVELS];

    busreq_pick #(
        .LEVELS(LEVELS),
        .LVL_W (LVL_W)
    ) u_pick (
        .req_act (req_act),
        .pol     (pol),
        .last_lvl(cur_lvl),
        .found   (found),
        .pick    (pick)
    );

    busreq_grant_fsm #(
        .LEVELS        (LEVELS),
        .LVL_W         (LVL_W),
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
        .TMR_W         (TMR_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .busy_act (busy_act),
        .found    (found),
        .pick     (pick),
        .grant_vec(grant_vec),
        .cur_lvl  (cur_lvl),
        .owned    (owned)
    );

    always_comb begin
        higher_pending = 1'b0;
        for (int i = 0; i < LEVELS; i++) begin
            if (req_act[i] && (LVL_W'(i) > cur_lvl)) begin
                higher_pending = 1'b1;
            end
        end
    end

    assign grant_n = ~grant_vec;
    assign clear_n = !((pol == POL_FIXED) && owned && busy_act && higher_pending);

endmodule

// File: rtl/busreq_arb_checker.sv
`timescale 1ns/1ps
module busreq_arb_checker #(
    parameter int unsigned LEVELS         = 4,
    parameter int unsigned TIMEOUT_CYCLES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        policy,
    input logic [LEVELS-1:0] grant_n,
    input logic              clear_n,
    input logic              busy_act
);

    logic        gnt_any;
    int unsigned gnt_cnt;

    assign gnt_any = |(~grant_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_cnt <= 0;
        end else if (gnt_any) begin
            gnt_cnt <= gnt_cnt + 1;
        end else begin
            gnt_cnt <= 0;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~grant_n)); // R2

    AST_SINGLE_TOP_ONLY: assert property (@(posedge clk) disable iff (rst)
        ($rose(gnt_any) && $past(policy[1])) |-> !grant_n[LEVELS-1]); // R5

    AST_GRANT_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
        $rose(gnt_any) |-> !$past(busy_act)); // R6

    AST_BUSY_DROPS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (gnt_any && busy_act) |=> !gnt_any); // R7

    AST_GRANT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        gnt_cnt <= TIMEOUT_CYCLES); // R8

    AST_CLEAR_FIXED_OWNED: assert property (@(posedge clk) disable iff (rst)
        !clear_n |-> (policy == 2'b00 && busy_act && !gnt_any)); // R9

endmodule

bind busreq_arbiter busreq_arb_checker #(
    .LEVELS        (LEVELS),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .policy  (policy),
    .grant_n (grant_n),
    .clear_n (clear_n),
    .busy_act(busy_act)
);

// File: tb/busreq_arbiter_tb.sv
`timescale 1ns/1ps
module busreq_arbiter_tb;

    localparam int unsigned LEVELS  = 4;
    localparam int unsigned TIMEOUT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  policy = 2'b00;
    logic [3:0]  req_n = 4'hF;
    logic        busy_n = 1'b1;
    logic [3:0]  grant_n;
    logic        clear_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    busreq_arbiter #(
        .LEVELS        (LEVELS),
        .SYNC_STAGES   (2),
        .TIMEOUT_CYCLES(TIMEOUT)
    ) u_dut (
        .clk    (clk),
        .rst    (rst),
        .policy (policy),
        .req_n  (req_n),
        .busy_n (busy_n),
        .grant_n(grant_n),
        .clear_n(clear_n)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int grant_level();
        int lvl = -1;
        for (int i = 0; i < 4; i++) begin
            if (!grant_n[i]) lvl = i;
        end
        return lvl;
    endfunction

    task automatic do_reset(input logic [1:0] pol);
        @(negedge clk);
        rst = 1'b1;
        policy = pol;
        req_n = 4'hF;
        busy_n = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic wait_grant(input int maxc, output int lvl);
        int multi = 0;
        lvl = -1;
        for (int c = 0; c < maxc && lvl < 0; c++) begin
            @(negedge clk);
            if ($countones(~grant_n) > 1) multi++;
            lvl = grant_level();
        end
        check(multi == 0, "R2", "cycles with several grants", multi, 0);
    endtask

    task automatic serve(input int exp_lvl, input logic [3:0] next_req, input string tag);
        int lvl;
        wait_grant(30, lvl);
        check(lvl == exp_lvl, tag, "granted level", lvl, exp_lvl);
        busy_n = 1'b0;
        tick(4);
        check(grant_n == 4'hF, "R7", "grant_n after busy", int'(grant_n), 15);
        req_n = next_req;
        busy_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        do_reset(2'b00);
        check(grant_n == 4'hF, "R1", "grant_n after reset", int'(grant_n), 15);
        check(clear_n == 1'b1, "R1", "clear_n after reset", int'(clear_n), 1);
        tick(8);
        check(grant_n == 4'hF, "R1", "grant_n with no request", int'(grant_n), 15);
    endtask

    task automatic t_latency();
        do_reset(2'b00);
        req_n = 4'b1101;
        tick(2);
        check(grant_n == 4'hF, "R10", "grant_n before third edge", int'(grant_n), 15);
        tick(1);
        check(grant_n == 4'b1101, "R10", "grant_n after third edge", int'(grant_n), 13);
        busy_n = 1'b0;
        tick(4);
        check(grant_n == 4'hF, "R7", "grant_n once owned", int'(grant_n), 15);
        req_n = 4'hF;
        busy_n = 1'b1;
        tick(4);
    endtask

    task automatic t_fixed();
        do_reset(2'b00);
        req_n = 4'b0000;
        serve(3, 4'b1010, "R3");
        serve(2, 4'b1110, "R3");
        serve(0, 4'hF, "R3");
    endtask

    task automatic t_rotate();
        do_reset(2'b01);
        req_n = 4'b0000;
        serve(3, 4'b0000, "R4");
        serve(2, 4'b0000, "R4");
        serve(1, 4'b0000, "R4");
        serve(0, 4'b0000, "R4");
        serve(3, 4'b0101, "R4");
        serve(1, 4'b0101, "R4");
        serve(3, 4'hF, "R4");
    endtask

    task automatic t_single();
        int lvl;
        do_reset(2'b10);
        req_n = 4'b1000;
        wait_grant(10, lvl);
        check(lvl == -1, "R5", "grant on low levels", lvl, -1);
        req_n = 4'b0000;
        serve(3, 4'hF, "R5");
        do_reset(2'b11);
        req_n = 4'b1000;
        wait_grant(10, lvl);
        check(lvl == -1, "R5", "grant on low levels, policy 3", lvl, -1);
    endtask

    task automatic t_busy_block();
        int lvl;
        do_reset(2'b00);
        busy_n = 1'b0;
        tick(3);
        req_n = 4'b1011;
        tick(8);
        check(grant_n == 4'hF, "R6", "grant_n while busy held", int'(grant_n), 15);
        busy_n = 1'b1;
        wait_grant(10, lvl);
        check(lvl == 2, "R6", "grant after busy release", lvl, 2);
        busy_n = 1'b0;
        tick(4);
        req_n = 4'hF;
        busy_n = 1'b1;
        tick(4);
    endtask

    task automatic t_timeout();
        int lvl;
        int cnt;
        do_reset(2'b00);
        req_n = 4'b1110;
        wait_grant(10, lvl);
        check(lvl == 0, "R8", "offered level", lvl, 0);
        cnt = 1;
        for (int c = 0; c < 40; c++) begin
            tick(1);
            if (grant_n == 4'hF) break;
            cnt++;
        end
        check(cnt == TIMEOUT, "R8", "cycles grant held", cnt, TIMEOUT);
        check(grant_n == 4'hF, "R8", "grant_n after timeout", int'(grant_n), 15);
        tick(1);
        check(grant_n == 4'b1110, "R8", "grant_n re-offered", int'(grant_n), 14);
        req_n = 4'hF;
        tick(20);
    endtask

    task automatic t_clear();
        int lvl;
        do_reset(2'b00);
        req_n = 4'b1101;
        wait_grant(10, lvl);
        check(lvl == 1, "R9", "owner level", lvl, 1);
        busy_n = 1'b0;
        tick(4);
        check(clear_n == 1'b1, "R9", "clear_n, same level", int'(clear_n), 1);
        req_n = 4'b1100;
        tick(4);
        check(clear_n == 1'b1, "R9", "clear_n, lower level", int'(clear_n), 1);
        req_n = 4'b1001;
        tick(4);
        check(clear_n == 1'b0, "R9", "clear_n, higher level", int'(clear_n), 0);
        check(grant_n == 4'hF, "R6", "grant_n while owned", int'(grant_n), 15);
        req_n = 4'b0101;
        policy = 2'b01;
        tick(4);
        check(clear_n == 1'b1, "R9", "clear_n, rotating", int'(clear_n), 1);
        policy = 2'b10;
        tick(4);
        check(clear_n == 1'b1, "R9", "clear_n, single-level", int'(clear_n), 1);
        policy = 2'b00;
        tick(4);
        check(clear_n == 1'b0, "R9", "clear_n, fixed again", int'(clear_n), 0);
        busy_n = 1'b1;
        tick(3);
        check(clear_n == 1'b1, "R9", "clear_n after release", int'(clear_n), 1);
        req_n = 4'hF;
        tick(20);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_fixed();
        t_rotate();
        t_single();
        t_busy_block();
        t_timeout();
        t_clear();
        finish_run();
    end

    initial begin
        #(8 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

endmodule